// File: doc/BRIEF.md
# Interrupt Pin Controller with Pulse and Level Modes

This block merges three event sources into one external interrupt pin: a watchdog expiry, an alarm match and a power-fail warning. Each source has its own enable bit in an 8-bit control register. An event whose enable is clear does not touch the pin. Detecting the events is outside this block; it receives each one as a one-cycle strobe.

The pin has two timing modes. In level mode it stays active until the system reads the flags register, which the block sees as a one-cycle read strobe. In pulse mode it stays active for a fixed number of ticks of a 32 Hz timebase, about 200 ms. The pin also has two drive modes. It can be a push-pull output that is active high, or an open-drain output that is active low. For the open-drain case the block provides a pin value and an output enable, so the pad can be modelled with a pull-up.

There is no data stream here, so there is no valid/ready interface. Every input and output is a plain control or status pin, sampled or updated on the rising clock edge.

Top module: `irq_pin_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, and the pin is released: `irq_oe` = 0 and `irq_pin` = 0.
- R2: A write stores bits 7, 6, 5, 3 and 2 of `cfg_wdata`. Bits 4, 1 and 0 always read back as 0, whatever was written to them. For example, writing 0xFF reads back 0xEC and writing 0x13 reads back 0x00.
- R3: Bit 7 enables the watchdog source, bit 6 the alarm source and bit 5 the power-fail source. An event strobe whose enable bit is 0 never makes the pin active.
- R4: When bit 3 is 1 (push-pull mode), `irq_oe` is held at 1 and `irq_pin` equals the interrupt-active state.
- R5: When bit 3 is 0 (open-drain mode), `irq_pin` is held at 0 and `irq_oe` is 1 only while the interrupt is active.
- R6: When bit 2 is 0 (level mode), an enabled event makes the pin active from the next cycle. The pin stays active until a `flags_rd` strobe and goes inactive in the cycle after it. If an enabled event arrives in the same cycle as the read, the pin stays active.
- R7: When bit 2 is 1 (pulse mode), an enabled event makes the pin active from the next cycle. The pin goes inactive in the cycle after the PULSE_TICKS-th `tick_32hz` strobe counted from that event. `flags_rd` has no effect in this mode.
- R8: In pulse mode, an enabled event during an active pulse restarts the count at PULSE_TICKS. An event in the same cycle as a tick takes precedence over that tick.
- R9: Any write to the control register clears any pending activity, so the pin is inactive in the next cycle. An event strobe in the same cycle as the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register contents, reserved bits read as 0 |
| evt_wdog | input | 1 | Watchdog expiry strobe |
| evt_alarm | input | 1 | Alarm match strobe |
| evt_pfail | input | 1 | Power-fail warning strobe |
| flags_rd | input | 1 | Flags register read strobe; releases the pin in level mode |
| tick_32hz | input | 1 | One-cycle strobe at 32 Hz; times the pulse |
| irq_pin | output | 1 | Value driven on the interrupt pin |
| irq_oe | output | 1 | Output enable for the interrupt pin |

## Verification
The assertions assume that every event, read and tick input is a strobe, high for one clock only. They also assume that the mode bits change only through a control write, because the properties use the mode from `cfg_rdata` both in the cycle of the cause and in the cycle of the effect. The bench drives every strobe for exactly one cycle at a falling edge. It leaves idle cycles between ticks, and it changes modes only through a write followed by a settle cycle. The one exception is the deliberate overlap of an event with a tick, which the design resolves on its own.

// File: rtl/irq_pin_pkg.sv
package irq_pin_pkg;
  localparam int unsigned NUM_SRC = 3;
  localparam int unsigned CFG_W   = 8;
  // Bits that a control write can set; all other bits are reserved.
  localparam logic [CFG_W-1:0] CFG_WMASK = 8'hEC;

  // Source index order matches the enable bits: index 2 is bit 7.
  localparam int unsigned SRC_PFAIL = 0;
  localparam int unsigned SRC_ALARM = 1;
  localparam int unsigned SRC_WDOG  = 2;

  typedef struct packed {
    logic       en_wdog;
    logic       en_alarm;
    logic       en_pfail;
    logic       rsv4;
    logic       act_high;
    logic       pulse_mode;
    logic [1:0] rsv10;
  } irq_cfg_t;
endpackage

// File: rtl/irq_cfg_reg.sv
module irq_cfg_reg
  import irq_pin_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CFG_W-1:0] wdata,
  output irq_cfg_t         cfg,
  output logic [CFG_W-1:0] rdata
);
  logic [CFG_W-1:0] store_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  store_q <= '0;
    else if (wr) store_q <= wdata & CFG_WMASK;
  end

  assign cfg   = irq_cfg_t'(store_q);
  assign rdata = store_q;
endmodule

// File: rtl/irq_src_gate.sv
module irq_src_gate #(
  parameter int unsigned N = 3
) (
  input  logic [N-1:0] evt,
  input  logic [N-1:0] en,
  output logic         fire
);
  logic [N-1:0] gated;

  for (genvar i = 0; i < N; i++) begin : g_src
    assign gated[i] = evt[i] & en[i];
  end

  assign fire = |gated;
endmodule

// File: rtl/irq_pulse_timer.sv
module irq_pulse_timer #(
  parameter int unsigned PULSE_TICKS = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic start,
  input  logic tick,
  output logic active
);
  localparam int unsigned CNT_W = $clog2(PULSE_TICKS + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_TICKS);

  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        left_q <= '0;
    else if (clr)                      left_q <= '0;
    else if (start)                    left_q <= LOAD;
    else if (tick && left_q != '0)     left_q <= left_q - 1'b1;
  end

  assign active = (left_q != '0);
endmodule

// File: rtl/irq_level_latch.sv
module irq_level_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic set,
  input  logic release_i,
  output logic active
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         active <= 1'b0;
    else if (clr)       active <= 1'b0;
    else if (set)       active <= 1'b1;
    else if (release_i) active <= 1'b0;
  end
endmodule

// File: rtl/irq_pin_drive.sv
module irq_pin_drive (
  input  logic active,
  input  logic act_high,
  output logic pin,
  output logic oe
);
  always_comb begin
    if (act_high) begin
      pin = active;
      oe  = 1'b1;
    end else begin
      pin = 1'b0;
      oe  = active;
    end
  end
endmodule

// File: rtl/irq_pin_ctrl.sv
module irq_pin_ctrl
  import irq_pin_pkg::*;
#(
  parameter int unsigned PULSE_TICKS = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  input  logic       evt_wdog,
  input  logic       evt_alarm,
  input  logic       evt_pfail,
  input  logic       flags_rd,
  input  logic       tick_32hz,
  output logic       irq_pin,
  output logic       irq_oe
);
  irq_cfg_t           cfg;
  logic [NUM_SRC-1:0] evt_vec;
  logic [NUM_SRC-1:0] en_vec;
  logic               fire;
  logic               pulse_act;
  logic               level_act;
  logic               irq_active;

  irq_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (cfg_wr),
    .wdata (cfg_wdata),
    .cfg   (cfg),
    .rdata (cfg_rdata)
  );

  always_comb begin
    evt_vec            = '0;
    en_vec             = '0;
    evt_vec[SRC_WDOG]  = evt_wdog;
    evt_vec[SRC_ALARM] = evt_alarm;
    evt_vec[SRC_PFAIL] = evt_pfail;
    en_vec[SRC_WDOG]   = cfg.en_wdog;
    en_vec[SRC_ALARM]  = cfg.en_alarm;
    en_vec[SRC_PFAIL]  = cfg.en_pfail;
  end

  irq_src_gate #(.N(NUM_SRC)) u_gate (
    .evt  (evt_vec),
    .en   (en_vec),
    .fire (fire)
  );

  irq_pulse_timer #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (cfg_wr),
    .start  (fire & cfg.pulse_mode),
    .tick   (tick_32hz),
    .active (pulse_act)
  );

  irq_level_latch u_level (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (cfg_wr),
    .set       (fire & ~cfg.pulse_mode),
    .release_i (flags_rd),
    .active    (level_act)
  );

  assign irq_active = cfg.pulse_mode ? pulse_act : level_act;

  irq_pin_drive u_drive (
    .active   (irq_active),
    .act_high (cfg.act_high),
    .pin      (irq_pin),
    .oe       (irq_oe)
  );
endmodule

// File: rtl/irq_pin_ctrl_chk.sv
module irq_pin_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_wr,
  input logic [7:0] cfg_rdata,
  input logic       evt_wdog,
  input logic       evt_alarm,
  input logic       evt_pfail,
  input logic       flags_rd,
  input logic       tick_32hz,
  input logic       irq_pin,
  input logic       irq_oe
);
  logic act_seen;
  logic en_evt;

  assign act_seen = cfg_rdata[3] ? irq_pin : irq_oe;
  assign en_evt   = |({evt_wdog, evt_alarm, evt_pfail} & cfg_rdata[7:5]);

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata & 8'h13) == 8'h00);

  assert_no_spurious_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_seen && !en_evt && !cfg_wr) |=> !act_seen);

  assert_pp_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[3] |-> irq_oe);

  assert_od_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[3] |-> !irq_pin);

  assert_event_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_evt && !cfg_wr) |=> act_seen);

  assert_level_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_rdata[2] && act_seen && !flags_rd && !cfg_wr) |=> act_seen);

  assert_level_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_rdata[2] && flags_rd && !en_evt && !cfg_wr) |=> !act_seen);

  assert_pulse_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[2] && act_seen && !tick_32hz && !cfg_wr) |=> act_seen);

  assert_write_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> !act_seen);
endmodule

bind irq_pin_ctrl irq_pin_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_wr    (cfg_wr),
  .cfg_rdata (cfg_rdata),
  .evt_wdog  (evt_wdog),
  .evt_alarm (evt_alarm),
  .evt_pfail (evt_pfail),
  .flags_rd  (flags_rd),
  .tick_32hz (tick_32hz),
  .irq_pin   (irq_pin),
  .irq_oe    (irq_oe)
);

// File: tb/irq_pin_ctrl_bench.sv
module irq_pin_ctrl_bench;
  localparam int unsigned PT = 7;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       evt_wdog = 1'b0;
  logic       evt_alarm = 1'b0;
  logic       evt_pfail = 1'b0;
  logic       flags_rd = 1'b0;
  logic       tick_32hz = 1'b0;
  logic       irq_pin;
  logic       irq_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_pin_ctrl #(.PULSE_TICKS(PT)) u_irq_pin_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .evt_wdog(evt_wdog), .evt_alarm(evt_alarm),
    .evt_pfail(evt_pfail), .flags_rd(flags_rd), .tick_32hz(tick_32hz),
    .irq_pin(irq_pin), .irq_oe(irq_oe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  // Checks both pins for an expected active state in the given drive mode.
  task automatic pin_is(input string req, input bit hi_mode, input bit act);
    if (hi_mode) chk(req, {6'd0, irq_oe, irq_pin}, {6'd0, 1'b1, act});
    else         chk(req, {6'd0, irq_oe, irq_pin}, {6'd0, act, 1'b0});
  endtask

  task automatic wr_cfg(input logic [7:0] v);
    cfg_wr = 1'b1; cfg_wdata = v; cyc();
    cfg_wr = 1'b0; cfg_wdata = '0;
  endtask

  task automatic fire(input bit w, input bit a, input bit p);
    evt_wdog = w; evt_alarm = a; evt_pfail = p; cyc();
    evt_wdog = 1'b0; evt_alarm = 1'b0; evt_pfail = 1'b0;
  endtask

  task automatic tick();
    tick_32hz = 1'b1; cyc(); tick_32hz = 1'b0; cyc();
  endtask

  task automatic rd_flags();
    flags_rd = 1'b1; cyc(); flags_rd = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 cfg", cfg_rdata, 8'h00);
    pin_is("R1 pin released", 1'b0, 1'b0);
  endtask

  task automatic t_register();
    wr_cfg(8'hFF);
    chk("R2 write FF", cfg_rdata, 8'hEC);
    wr_cfg(8'h13);
    chk("R2 reserved only", cfg_rdata, 8'h00);
  endtask

  task automatic t_gating();
    wr_cfg(8'h48); // alarm only, push-pull, level
    fire(1'b1, 1'b0, 1'b0);
    pin_is("R3 watchdog disabled", 1'b1, 1'b0);
    fire(1'b0, 1'b0, 1'b1);
    pin_is("R3 power-fail disabled", 1'b1, 1'b0);
    fire(1'b0, 1'b1, 1'b0);
    pin_is("R3 alarm enabled / R4", 1'b1, 1'b1);
  endtask

  task automatic t_level();
    wr_cfg(8'hE8);
    fire(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 5; i++) cyc();
    tick(); tick();
    pin_is("R6 held without read", 1'b1, 1'b1);
    flags_rd = 1'b1; evt_pfail = 1'b1; cyc();
    flags_rd = 1'b0; evt_pfail = 1'b0;
    pin_is("R6 event beats read", 1'b1, 1'b1);
    rd_flags();
    pin_is("R6 read releases", 1'b1, 1'b0);
  endtask

  task automatic t_open_drain();
    wr_cfg(8'hE0);
    pin_is("R5 idle released", 1'b0, 1'b0);
    fire(1'b0, 1'b1, 1'b0);
    pin_is("R5 active drives low", 1'b0, 1'b1);
    rd_flags();
    pin_is("R5 released after read", 1'b0, 1'b0);
  endtask

  task automatic t_pulse();
    wr_cfg(8'hEC);
    fire(1'b0, 1'b0, 1'b1);
    pin_is("R7 pulse starts", 1'b1, 1'b1);
    for (int i = 0; i < PT - 1; i++) tick();
    rd_flags();
    pin_is("R7 read ignored, before last tick", 1'b1, 1'b1);
    tick();
    pin_is("R7 ends after last tick", 1'b1, 1'b0);
  endtask

  task automatic t_retrigger();
    wr_cfg(8'hE4); // pulse mode, open drain
    fire(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) tick();
    evt_alarm = 1'b1; tick_32hz = 1'b1; cyc(); // event with tick: reload wins
    evt_alarm = 1'b0; tick_32hz = 1'b0; cyc();
    for (int i = 0; i < PT - 1; i++) tick();
    pin_is("R8 restarted count still active", 1'b0, 1'b1);
    tick();
    pin_is("R8 ends after full restarted count", 1'b0, 1'b0);
  endtask

  task automatic t_cfg_clear();
    wr_cfg(8'hE8);
    fire(1'b1, 1'b1, 1'b1);
    pin_is("R9 setup active", 1'b1, 1'b1);
    wr_cfg(8'hE8);
    pin_is("R9 write clears", 1'b1, 1'b0);
    cfg_wr = 1'b1; cfg_wdata = 8'hE8; evt_wdog = 1'b1; cyc();
    cfg_wr = 1'b0; evt_wdog = 1'b0;
    pin_is("R9 event with write dropped", 1'b1, 1'b0);
  endtask

  initial begin
    cyc(); cyc();
    t_reset();
    rst_n = 1'b1;
    cyc();
    t_reset();
    t_register();
    t_gating();
    t_level();
    t_open_drain();
    t_pulse();
    t_retrigger();
    t_cfg_clear();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule